// File: doc/BRIEF.md
# Rate-Coded Spike Encoder With Noise

The encoder turns a stored image of 8-bit pixel intensities into a stream of spike events, one input neuron per pixel (784 neurons for a 28 x 28 image by default). On each timestep tick it visits every pixel once. A pixel fires with a probability proportional to its intensity, and that probability is normalised by the frame's intensity sum, so the expected number of spikes per tick across the whole population equals a configured total, whatever the image looks like.

Input noise is modelled without changing the spike count. Each spike that fires may be moved, with a configured probability, to an input neuron drawn uniformly from the whole population. Two 16-bit pseudo-random generators, each with a loadable seed, supply the firing draw and the noise draws, so a spike sequence can be reproduced exactly. Spikes leave as neuron indices on a valid/ready stream, and back-pressure stalls the scan without dropping events.

Top module: `spike_rate_encoder`

## Requirements
- R1: After reset `spk_valid` and `busy` are 0.
- R2: A write with `pix_we` stores `pix_data` at pixel `pix_addr`. A `tick` while `busy` is 0 and `frame_sum` is nonzero raises `busy` on the next cycle. The encoder then scans pixels 0 to NPIX-1 once, and with noise off it emits the spikes in ascending index order.
- R3: The scale is floor(`rate_cfg` * 65536 / `frame_sum`). Pixel i fires when the firing generator's value is at most min(65535, (intensity_i * scale) >> 8). A pixel of intensity 0 never fires. A threshold that saturates at 65535 always fires. The expected total is `rate_cfg`/256 spikes per tick.
- R4: Across pixels, the firing frequencies are proportional to the intensities.
- R5: A `tick` with `frame_sum` equal to 0 produces no spikes and leaves `busy` at 0, with no division performed.
- R6: Each fired spike is relocated when the low 8 bits of the noise generator, read as an unsigned value, are below `noise_lvl` (9 bits: 0 means never, 256 means always). A relocated spike replaces its index with a fresh 10-bit draw from the top bits of the noise generator, and a draw of NPIX or more is rejected and redrawn. Relocation never adds or removes spikes.
- R7: While `spk_valid` is 1 and `spk_ready` is 0, `spk_valid` stays 1 and `spk_idx` stays unchanged. No spike is lost.
- R8: `seed_load` loads `seed_a` into the firing generator and `seed_b` into the noise generator, and a seed of 0 is loaded as 1. The same seeds with the same frame and configuration give the same spike sequence.
- R9: A `tick` that arrives while `busy` is 1 is ignored.
- R10: `spk_idx` is always below NPIX while `spk_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_we | input | 1 | Pixel memory write enable |
| pix_addr | input | IDX_W (10) | Pixel index to write |
| pix_data | input | PIX_W (8) | Pixel intensity |
| frame_sum | input | SUM_W (18) | Sum of all intensities in the frame |
| rate_cfg | input | RATE_W (16) | Total spikes per tick, times 256 |
| noise_lvl | input | PIX_W+1 (9) | Relocation probability, in 1/256 steps |
| seed_load | input | 1 | Load both generator seeds |
| seed_a | input | 16 | Seed for the firing generator |
| seed_b | input | 16 | Seed for the noise generator |
| tick | input | 1 | Timestep strobe that starts a scan |
| busy | output | 1 | A scan is in progress |
| spk_valid | output | 1 | Spike index is valid |
| spk_ready | input | 1 | Downstream accepts the spike |
| spk_idx | output | IDX_W (10) | Index of the neuron that fired |

## Verification
The bench drives a sparse frame whose thresholds saturate, so the exact list of spikes is known. A design that misordered the scan, fired zero pixels, skipped the last pixel or dropped spikes under random back-pressure would return a different list, and a tick issued mid-scan would expose a design that restarts and duplicates spikes. With full and half noise, the spike count must match the noise-free count exactly. A design that adds spikes instead of moving them, or that emits indices past the population, fails there. Long runs compare spike totals against the configured rate and the intensity ratio, which catches a wrong normalisation. Replaying with the same seeds, and treating a zero seed as one, catches generators that are not reloaded properly or that lock up.

// File: rtl/spk_enc_pkg.sv
package spk_enc_pkg;
  localparam int RND_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_SCAN,
    ST_DRAW,
    ST_EMIT
  } enc_state_e;

  // Galois step, polynomial x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [RND_W-1:0] rnd_next(input logic [RND_W-1:0] s);
    rnd_next = s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction
endpackage

// File: rtl/spk_enc_lfsr.sv
module spk_enc_lfsr
  import spk_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RND_W-1:0] seed,
  input  logic             step,
  output logic [RND_W-1:0] value
);
  logic [RND_W-1:0] s_q, s_d;

  always_comb begin
    s_d = s_q;
    if (load) s_d = (seed == '0) ? RND_W'(1) : seed;
    else if (step) s_d = rnd_next(s_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= RND_W'(1);
    else if (load || step) s_q <= s_d;
  end

  assign value = s_q;
endmodule

// File: rtl/spk_enc_divider.sv
module spk_enc_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q, q_d;
  logic [DEN_W-1:0] r_q, r_d, den_q, den_d;
  logic [CNT_W-1:0] c_q, c_d;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  always_comb begin
    trial = {r_q, q_q[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    ge    = (trial >= {1'b0, den_q});
    q_d   = q_q;
    r_d   = r_q;
    c_d   = c_q;
    den_d = den_q;
    if (start) begin
      q_d   = num;
      r_d   = '0;
      c_d   = CNT_W'(NUM_W);
      den_d = den;
    end else if (c_q != '0) begin
      r_d = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      q_d = {q_q[NUM_W-2:0], ge};
      c_d = c_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      r_q   <= '0;
      c_q   <= '0;
      den_q <= '0;
    end else if (start || (c_q != '0)) begin
      q_q   <= q_d;
      r_q   <= r_d;
      c_q   <= c_d;
      den_q <= den_d;
    end
  end

  assign busy = (c_q != '0);
  assign quot = q_q;
endmodule

// File: rtl/spike_rate_encoder.sv
module spike_rate_encoder
  import spk_enc_pkg::*;
#(
  parameter int NPIX   = 784,
  parameter int PIX_W  = 8,
  parameter int RATE_W = 16,
  parameter int SUM_W  = 18,
  parameter int IDX_W  = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_we,
  input  logic [IDX_W-1:0]  pix_addr,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic [SUM_W-1:0]  frame_sum,
  input  logic [RATE_W-1:0] rate_cfg,
  input  logic [PIX_W:0]    noise_lvl,
  input  logic              seed_load,
  input  logic [RND_W-1:0]  seed_a,
  input  logic [RND_W-1:0]  seed_b,
  input  logic              tick,
  output logic              busy,
  output logic              spk_valid,
  input  logic              spk_ready,
  output logic [IDX_W-1:0]  spk_idx
);
  localparam int NUM_W  = RATE_W + RND_W;
  localparam int PROD_W = PIX_W + NUM_W;
  localparam int SHIFT  = 8;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  logic [PIX_W-1:0] pix_mem [NPIX];

  enc_state_e        st_q, st_d;
  logic [IDX_W-1:0]  addr_q, addr_d, idx_q, idx_d;
  logic              div_start, div_busy, step_a, step_b;
  logic [NUM_W-1:0]  scale;
  logic [RND_W-1:0]  rnd_a, rnd_b;
  logic [PROD_W-1:0] prod;
  logic [RND_W-1:0]  thr;
  logic              fire, relocate;
  logic [IDX_W-1:0]  cand;

  always_ff @(posedge clk) begin
    if (pix_we && (pix_addr < IDX_W'(NPIX))) pix_mem[pix_addr] <= pix_data;
  end

  spk_enc_divider #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num({rate_cfg, {RND_W{1'b0}}}), .den(frame_sum),
    .busy(div_busy), .quot(scale)
  );

  spk_enc_lfsr u_rnd_fire (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_a),
    .step(step_a), .value(rnd_a)
  );

  spk_enc_lfsr u_rnd_noise (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_b),
    .step(step_b), .value(rnd_b)
  );

  // firing threshold with saturation
  always_comb begin
    prod = PROD_W'(pix_mem[addr_q]) * PROD_W'(scale);
    if (|prod[PROD_W-1:SHIFT+RND_W]) thr = '1;
    else thr = prod[SHIFT+RND_W-1:SHIFT];
    fire     = (rnd_a <= thr);
    relocate = ({1'b0, rnd_b[PIX_W-1:0]} < noise_lvl);
    cand     = rnd_b[RND_W-1 -: IDX_W];
  end

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    idx_d     = idx_q;
    div_start = 1'b0;
    step_a    = 1'b0;
    step_b    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tick && (frame_sum != '0)) begin
          div_start = 1'b1;
          addr_d    = '0;
          st_d      = ST_DIV;
        end
      end
      ST_DIV: begin
        if (!div_busy) st_d = ST_SCAN;
      end
      ST_SCAN: begin
        step_a = 1'b1;
        if (fire) begin
          step_b = 1'b1;
          if (relocate) st_d = ST_DRAW;
          else begin
            idx_d = addr_q;
            st_d  = ST_EMIT;
          end
        end else if (addr_q == LAST) begin
          st_d = ST_IDLE;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      ST_DRAW: begin
        step_b = 1'b1;
        if (cand < IDX_W'(NPIX)) begin
          idx_d = cand;
          st_d  = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (spk_ready) begin
          if (addr_q == LAST) st_d = ST_IDLE;
          else begin
            addr_d = addr_q + 1'b1;
            st_d   = ST_SCAN;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      idx_q  <= idx_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign spk_valid = (st_q == ST_EMIT);
  assign spk_idx   = idx_q;
endmodule

// File: rtl/spk_enc_checker.sv
module spk_enc_checker #(
  parameter int NPIX  = 784,
  parameter int IDX_W = 10,
  parameter int SUM_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             busy,
  input logic [SUM_W-1:0] frame_sum,
  input logic             spk_valid,
  input logic             spk_ready,
  input logic [IDX_W-1:0] spk_idx
);
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    spk_valid |-> (spk_idx < IDX_W'(NPIX))); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_valid && !spk_ready) |=> (spk_valid && $stable(spk_idx))); // R7

  AST_ZERO_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !busy && (frame_sum == '0)) |=> !busy); // R5

  AST_TICK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !busy && (frame_sum != '0)) |=> busy); // R2
endmodule

bind spike_rate_encoder spk_enc_checker #(
  .NPIX(NPIX), .IDX_W(IDX_W), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .frame_sum(frame_sum),
  .spk_valid(spk_valid), .spk_ready(spk_ready), .spk_idx(spk_idx)
);

// File: tb/spike_rate_encoder_test.sv
module spike_rate_encoder_test;
  localparam int NPIX = 784;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_we;
  logic [9:0]  pix_addr;
  logic [7:0]  pix_data;
  logic [17:0] frame_sum;
  logic [15:0] rate_cfg;
  logic [8:0]  noise_lvl;
  logic        seed_load;
  logic [15:0] seed_a, seed_b;
  logic        tick;
  logic        busy, spk_valid, spk_ready;
  logic [9:0]  spk_idx;

  int n_tests = 0;
  int n_fail  = 0;
  int ready_mode = 0;   // 0 always, 1 random, 2 held low
  int rec [0:4095];
  int rec_n = 0;
  int img [NPIX];
  bit done = 0;

  always #4 clk = ~clk;

  spike_rate_encoder uut (
    .clk(clk), .rst_n(rst_n), .pix_we(pix_we), .pix_addr(pix_addr),
    .pix_data(pix_data), .frame_sum(frame_sum), .rate_cfg(rate_cfg),
    .noise_lvl(noise_lvl), .seed_load(seed_load), .seed_a(seed_a),
    .seed_b(seed_b), .tick(tick), .busy(busy), .spk_valid(spk_valid),
    .spk_ready(spk_ready), .spk_idx(spk_idx)
  );

  // ready driver and output monitor, away from the active edge
  always @(negedge clk) begin
    if (ready_mode == 0) spk_ready = 1'b1;
    else if (ready_mode == 1) spk_ready = 1'($urandom % 2);
    else spk_ready = 1'b0;
    if (rst_n && spk_valid && spk_ready && rec_n < 4096) begin
      rec[rec_n] = int'(spk_idx);
      rec_n++;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_frame(output int sum);
    sum = 0;
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      pix_we = 1'b1; pix_addr = 10'(i); pix_data = 8'(img[i]);
      sum += img[i];
    end
    @(negedge clk);
    pix_we = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 30000) begin
      @(negedge clk);
      guard++;
    end
    check(!busy, "R2", "scan did not finish", int'(busy), 0);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic load_seeds(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); seed_load = 1'b1; seed_a = a; seed_b = b;
    @(negedge clk); seed_load = 1'b0;
  endtask

  task automatic sparse_frame();
    for (int i = 0; i < NPIX; i++) img[i] = (i % 5 == 0) ? 1 + ($urandom % 255) : 0;
  endtask

  int sum, cnt, off, hi, lo, mism;
  int copy [0:4095];
  int copy_n;

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; pix_we = 0; pix_addr = 0; pix_data = 0; frame_sum = 0;
    rate_cfg = 0; noise_lvl = 0; seed_load = 0; seed_a = 0; seed_b = 0; tick = 0;
    spk_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!spk_valid && !busy, "R1", "outputs after reset", int'({busy, spk_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!spk_valid && !busy, "R1", "outputs after release", int'({busy, spk_valid}), 0);

    // R5: zero frame sum
    sparse_frame();
    write_frame(sum);
    frame_sum = 0; rate_cfg = 16'hFFFF; rec_n = 0;
    pulse_tick();
    check(!busy, "R5", "busy after zero-sum tick", int'(busy), 0);
    repeat (50) @(negedge clk);
    check(rec_n == 0, "R5", "spikes from zero-sum frame", rec_n, 0);

    // R2 R3 R7: saturated sparse frame, exact ordered list
    ready_mode = 1; frame_sum = 18'd1; noise_lvl = 0; rec_n = 0;
    pulse_tick();
    wait_idle();
    check(rec_n == 157, "R3", "saturated spike count", rec_n, 157);
    mism = 0;
    for (int k = 0; k < rec_n && k < 157; k++) if (rec[k] != 5 * k) mism++;
    check(mism == 0, "R2", "scan order mismatches", mism, 0);

    // R9: tick during a scan is ignored
    rec_n = 0;
    pulse_tick();
    repeat (100) @(negedge clk);
    pulse_tick();
    wait_idle();
    repeat (200) @(negedge clk);
    check(rec_n == 157, "R9", "count with tick while busy", rec_n, 157);

    // R7: held stall keeps index
    ready_mode = 2; rec_n = 0;
    pulse_tick();
    repeat (60) @(negedge clk);
    cnt = int'(spk_idx);
    repeat (20) @(negedge clk);
    check(spk_valid && int'(spk_idx) == cnt && cnt == 0, "R7", "stalled index", int'(spk_idx), 0);
    ready_mode = 0;
    wait_idle();
    check(rec_n == 157, "R7", "no loss after stall", rec_n, 157);

    // R6 R10: full relocation
    noise_lvl = 9'd256; rec_n = 0; off = 0; mism = 0;
    pulse_tick();
    wait_idle();
    for (int k = 0; k < rec_n; k++) begin
      if (rec[k] % 5 != 0) off++;
      if (rec[k] >= NPIX) mism++;
    end
    check(rec_n == 157, "R6", "count with full noise", rec_n, 157);
    check(off > 100, "R6", "relocated off-pattern count", off, 126);
    check(mism == 0, "R10", "indices out of range", mism, 0);

    // R6: half relocation over ten ticks
    noise_lvl = 9'd128; rec_n = 0; off = 0; ready_mode = 1;
    for (int t = 0; t < 10; t++) begin pulse_tick(); wait_idle(); end
    for (int k = 0; k < rec_n; k++) if (rec[k] % 5 != 0) off++;
    check(rec_n == 1570, "R6", "count with half noise", rec_n, 1570);
    check(off >= 540 && off <= 720, "R6", "half-noise off-pattern count", off, 628);

    // R3: total rate on a dense random frame
    for (int i = 0; i < NPIX; i++) img[i] = 1 + ($urandom % 255);
    write_frame(sum);
    frame_sum = 18'(sum); rate_cfg = 16'(20 * 256); noise_lvl = 0; rec_n = 0;
    for (int t = 0; t < 40; t++) begin pulse_tick(); wait_idle(); end
    check(rec_n >= 680 && rec_n <= 920, "R3", "spikes over 40 ticks", rec_n, 800);

    // R4: proportionality, intensity 200 versus 50
    for (int i = 0; i < NPIX; i++) img[i] = (i < NPIX / 2) ? 200 : 50;
    write_frame(sum);
    frame_sum = 18'(sum); rec_n = 0; hi = 0; lo = 0;
    for (int t = 0; t < 40; t++) begin pulse_tick(); wait_idle(); end
    for (int k = 0; k < rec_n; k++) if (rec[k] < NPIX / 2) hi++; else lo++;
    check(hi * 10 >= lo * 28 && hi * 10 <= lo * 55, "R4", "bright half count", hi, lo * 4);

    // R8: replay with the same seeds
    for (int i = 0; i < NPIX; i++) img[i] = $urandom % 256;
    write_frame(sum);
    frame_sum = 18'(sum); rate_cfg = 16'(30 * 256); noise_lvl = 9'd64;
    load_seeds(16'h1234, 16'h00AB); rec_n = 0;
    for (int t = 0; t < 5; t++) begin pulse_tick(); wait_idle(); end
    copy_n = rec_n;
    for (int k = 0; k < copy_n; k++) copy[k] = rec[k];
    load_seeds(16'h1234, 16'h00AB); rec_n = 0;
    for (int t = 0; t < 5; t++) begin pulse_tick(); wait_idle(); end
    mism = 0;
    for (int k = 0; k < copy_n && k < rec_n; k++) if (rec[k] != copy[k]) mism++;
    check(rec_n == copy_n && copy_n > 0, "R8", "replay count", rec_n, copy_n);
    check(mism == 0, "R8", "replay mismatches", mism, 0);

    // R8: zero seed behaves as seed one
    load_seeds(16'h0000, 16'h0000); rec_n = 0;
    pulse_tick(); wait_idle();
    copy_n = rec_n;
    for (int k = 0; k < copy_n; k++) copy[k] = rec[k];
    load_seeds(16'h0001, 16'h0001); rec_n = 0;
    pulse_tick(); wait_idle();
    mism = 0;
    for (int k = 0; k < copy_n && k < rec_n; k++) if (rec[k] != copy[k]) mism++;
    check(rec_n == copy_n && mism == 0, "R8", "zero-seed mismatches", mism, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule